// File: doc/BRIEF.md
# Frame-Count Threshold Breakpoint Generator

This block sits on the receive path and turns three kinds of activity into interrupt breakpoints: the close of a service opportunity, a change of the receive channel (a burst boundary), and the expiry of a frame budget. Software programs an 8-bit frame budget and a small mode word that enables each breakpoint source on its own. A working down-counter is loaded from the budget at each burst boundary and whenever it expires. Each received frame takes one count from it.

A burst boundary is a frame strobe whose channel identifier differs from the channel of the previous frame. The channel tracker resets to channel 0. When a boundary and a frame arrive together, the counter reloads first and the frame then counts against the new burst. The mode word is locked while the run input is high. The budget can be rewritten at any time, but a new value only takes effect at the next reload.

Every breakpoint is reported as a one-cycle pulse with a 2-bit cause code, registered one clock after the triggering inputs. When several sources fire in the same cycle, only the highest-priority one is reported.

Top module: `frame_bkpt_gen`

## Requirements
- R1: After reset, `bkpt_o` is 0 and `bkpt_cause_o` is 00. All three sources are disabled. The budget register holds 0, which means 256, and the tracked channel is 0.
- R2: The mode word is written from `cfg_mode_i` when `cfg_mode_wr_i` is high and `run_i` is low. When `run_i` is high, such a write is ignored. Mode bit 2 enables threshold breakpoints, bit 1 enables burst breakpoints and bit 0 enables service breakpoints.
- R3: Each frame strobe decrements the working count. The frame that would bring it to zero is a threshold expiry, and the counter then reloads from the budget. When mode bit 2 is set, an expiry yields cause 01.
- R4: A budget of 0x00 gives 256 frames between threshold breakpoints. A budget of N from 1 to 255 gives N frames, so a budget of 1 expires on every frame.
- R5: A frame on a channel different from the previous frame's channel reloads the working count from the budget before that frame is counted.
- R6: A channel change while mode bit 1 is set yields cause 10.
- R7: A pulse on `svc_end_i` while mode bit 0 is set yields cause 11.
- R8: When several causes are raised in the same cycle, a single pulse is reported. Threshold wins over burst, and burst wins over service.
- R9: A disabled source produces no pulse. The working count keeps running while threshold breakpoints are disabled.
- R10: `bkpt_o` is high for exactly the clock after the triggering inputs. `bkpt_cause_o` is 00 whenever `bkpt_o` is low.
- R11: Writing the budget does not change the running count. The new value is used only at the next reload, which is either a channel change or an expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_i | input | 1 | Receive machine running; locks the mode word |
| cfg_mode_wr_i | input | 1 | Mode word write strobe |
| cfg_mode_i | input | 3 | Mode word: [2] threshold, [1] burst, [0] service |
| cfg_thr_wr_i | input | 1 | Frame budget write strobe |
| cfg_thr_i | input | 8 | Frame budget (0 means 256) |
| frame_i | input | 1 | One pulse per received frame |
| chan_i | input | 3 | Channel of the frame on `frame_i` |
| svc_end_i | input | 1 | End-of-service-opportunity pulse |
| bkpt_o | output | 1 | Breakpoint event pulse |
| bkpt_cause_o | output | 2 | 01 threshold, 10 burst, 11 service, 00 idle |

## Verification
The assertions take for granted that `chan_i` is meaningful only in cycles where `frame_i` is high, and that the inputs hold no unknown values after reset. The stimulus changes the channel only together with a frame strobe, and it drives every input to a defined level from time zero. It writes the mode word both with `run_i` low and with `run_i` high. It also places service pulses, channel changes and expiries in the same cycles, so that the priority order is exercised.

// File: rtl/fbk_pkg.sv
// Shared constants for the frame breakpoint generator.
// Assumes: cause code 2'b00 means "no event".
package fbk_pkg;
    localparam int MODE_W  = 3;
    localparam int M_SVC   = 0;
    localparam int M_BURST = 1;
    localparam int M_THR   = 2;

    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'b00,
        CAUSE_THR   = 2'b01,
        CAUSE_BURST = 2'b10,
        CAUSE_SVC   = 2'b11
    } cause_e;
endpackage

// File: rtl/fbk_cfg_regs.sv
// Holds the mode word and the frame budget.
// Assumes: mode writes arrive only from the host port; while run_i is high
// they are dropped. Budget writes are always accepted.
module fbk_cfg_regs
    import fbk_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              mode_wr_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              thr_wr_i,
    input  logic [CNT_W-1:0]  thr_i,
    output logic [MODE_W-1:0] mode_o,
    output logic [CNT_W-1:0]  thr_o
);
    logic [MODE_W-1:0] mode_q;
    logic [CNT_W-1:0]  thr_q;

    // Mode word: accepted only while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n)                   mode_q <= '0;
        else if (mode_wr_i && !run_i) mode_q <= mode_i;
    end

    // Frame budget: accepted at any time.
    always_ff @(posedge clk) begin
        if (!rst_n)        thr_q <= '0;
        else if (thr_wr_i) thr_q <= thr_i;
    end

    assign mode_o = mode_q;
    assign thr_o  = thr_q;

    // R2
    mode_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |=> $stable(mode_q));
endmodule

// File: rtl/fbk_burst_detect.sv
// Tracks the channel of the last frame and flags a burst boundary when a
// frame arrives on another channel.
// Assumes: chan_i is valid only while frame_i is high.
module fbk_burst_detect #(
    parameter int CH_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frame_i,
    input  logic [CH_W-1:0] chan_i,
    output logic            change_o
);
    logic [CH_W-1:0] cur_q;

    // Remember the channel of the latest frame.
    always_ff @(posedge clk) begin
        if (!rst_n)       cur_q <= '0;
        else if (frame_i) cur_q <= chan_i;
    end

    assign change_o = frame_i && (chan_i != cur_q);

    // R5
    chan_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_i |=> (cur_q == $past(chan_i)));
endmodule

// File: rtl/fbk_frame_counter.sv
// Working down-counter of frames left in the current budget.
// Assumes: reload_i is raised only together with frame_i. The count holds
// values from 1 to 2**CNT_W; a budget of zero loads the full range.
module fbk_frame_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_i,
    input  logic             reload_i,
    input  logic [CNT_W-1:0] thr_i,
    output logic             expire_o
);
    localparam int LD_W = CNT_W + 1;
    localparam logic [LD_W-1:0] FULL = LD_W'(1) << CNT_W;

    logic [LD_W-1:0] cnt_q;
    logic [LD_W-1:0] load_val;
    logic [LD_W-1:0] base;

    // Value to load: zero budget stands for the full range.
    always_comb begin
        load_val = (thr_i == '0) ? FULL : {1'b0, thr_i};
        base     = reload_i ? load_val : cnt_q;
    end

    assign expire_o = frame_i && (base == LD_W'(1));

    // Count frames; reload on expiry; reset state is the full range.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt_q <= FULL;
        else if (expire_o) cnt_q <= load_val;
        else if (frame_i)  cnt_q <= base - LD_W'(1);
    end

    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) && (cnt_q <= FULL));
    // R3
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_i |=> $stable(cnt_q));
endmodule

// File: rtl/fbk_cause_arb.sv
// Picks one cause among the enabled raw events and registers the pulse.
// Assumes: raw events are single-cycle, qualified by the mode word here.
module fbk_cause_arb
    import fbk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              thr_evt_i,
    input  logic              burst_evt_i,
    input  logic              svc_evt_i,
    output logic              bkpt_o,
    output logic [1:0]        cause_o
);
    cause_e pick;
    logic   bkpt_q;
    cause_e cause_q;

    // Priority select: threshold, then burst, then service.
    always_comb begin
        if (thr_evt_i && mode_i[M_THR])          pick = CAUSE_THR;
        else if (burst_evt_i && mode_i[M_BURST]) pick = CAUSE_BURST;
        else if (svc_evt_i && mode_i[M_SVC])     pick = CAUSE_SVC;
        else                                     pick = CAUSE_NONE;
    end

    // Register the pulse and its cause.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bkpt_q  <= 1'b0;
            cause_q <= CAUSE_NONE;
        end else begin
            bkpt_q  <= (pick != CAUSE_NONE);
            cause_q <= pick;
        end
    end

    assign bkpt_o  = bkpt_q;
    assign cause_o = cause_q;

    // R10
    idle_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bkpt_q |-> (cause_q == CAUSE_NONE));
    // R9
    svc_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_i[M_SVC] && !mode_i[M_BURST] && !mode_i[M_THR]) |=> !bkpt_q);
endmodule

// File: rtl/frame_bkpt_gen.sv
// Top of the frame breakpoint generator: configuration, burst detection,
// frame budget counter and cause arbitration.
// Assumes: one frame strobe per cycle at most; chan_i valid with frame_i.
module frame_bkpt_gen
    import fbk_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int CH_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              cfg_mode_wr_i,
    input  logic [MODE_W-1:0] cfg_mode_i,
    input  logic              cfg_thr_wr_i,
    input  logic [CNT_W-1:0]  cfg_thr_i,
    input  logic              frame_i,
    input  logic [CH_W-1:0]   chan_i,
    input  logic              svc_end_i,
    output logic              bkpt_o,
    output logic [1:0]        bkpt_cause_o
);
    logic [MODE_W-1:0] mode;
    logic [CNT_W-1:0]  thr;
    logic              chg;
    logic              expire;

    fbk_cfg_regs #(.CNT_W(CNT_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .run_i(run_i),
        .mode_wr_i(cfg_mode_wr_i), .mode_i(cfg_mode_i),
        .thr_wr_i(cfg_thr_wr_i), .thr_i(cfg_thr_i),
        .mode_o(mode), .thr_o(thr)
    );

    fbk_burst_detect #(.CH_W(CH_W)) u_burst (
        .clk(clk), .rst_n(rst_n), .frame_i(frame_i), .chan_i(chan_i),
        .change_o(chg)
    );

    fbk_frame_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .frame_i(frame_i), .reload_i(chg),
        .thr_i(thr), .expire_o(expire)
    );

    fbk_cause_arb u_arb (
        .clk(clk), .rst_n(rst_n), .mode_i(mode),
        .thr_evt_i(expire), .burst_evt_i(chg), .svc_evt_i(svc_end_i),
        .bkpt_o(bkpt_o), .cause_o(bkpt_cause_o)
    );

    // R8
    thr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && mode[M_THR]) |=> (bkpt_o && bkpt_cause_o == CAUSE_THR));
    // R6
    burst_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chg && mode[M_BURST] && !(expire && mode[M_THR]))
            |=> (bkpt_cause_o == CAUSE_BURST));
    // R7
    svc_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_end_i && mode[M_SVC]) |=> bkpt_o);
endmodule

// File: tb/frame_bkpt_gen_bench.sv
// Scoreboard bench: drivers push expected results, a monitor compares them.
module frame_bkpt_gen_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_i = 1'b0;
    logic       cfg_mode_wr_i = 1'b0;
    logic [2:0] cfg_mode_i = '0;
    logic       cfg_thr_wr_i = 1'b0;
    logic [7:0] cfg_thr_i = '0;
    logic       frame_i = 1'b0;
    logic [2:0] chan_i = '0;
    logic       svc_end_i = 1'b0;
    logic       bkpt_o;
    logic [1:0] bkpt_cause_o;

    frame_bkpt_gen u_frame_bkpt_gen (
        .clk(clk), .rst_n(rst_n), .run_i(run_i),
        .cfg_mode_wr_i(cfg_mode_wr_i), .cfg_mode_i(cfg_mode_i),
        .cfg_thr_wr_i(cfg_thr_wr_i), .cfg_thr_i(cfg_thr_i),
        .frame_i(frame_i), .chan_i(chan_i), .svc_end_i(svc_end_i),
        .bkpt_o(bkpt_o), .bkpt_cause_o(bkpt_cause_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        bit       v;
        bit [1:0] c;
        string    req;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    // Reference state, kept from the requirements.
    bit [2:0] m_mode = '0;
    bit [7:0] m_thr  = '0;
    int       m_cnt  = 256;
    bit [2:0] m_chan = '0;

    function automatic int ld(bit [7:0] t);
        return (t == 0) ? 256 : int'(t);
    endfunction

    // Monitor: the item pushed before an edge is due just after that edge.
    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_chk++;
            if (bkpt_o !== e.v || bkpt_cause_o !== e.c) begin
                n_bad++;
                $display("FAIL %s: got pulse=%0b cause=%0b, expected pulse=%0b cause=%0b",
                         e.req, bkpt_o, bkpt_cause_o, e.v, e.c);
            end
        end
    end

    // One stimulus cycle on the receive side.
    task automatic cyc(bit fr, bit [2:0] ch, bit sv);
        exp_t e;
        bit   chg, ex, t, b, s;
        int   base;
        @(negedge clk);
        frame_i = fr; chan_i = ch; svc_end_i = sv;
        cfg_mode_wr_i = 1'b0; cfg_thr_wr_i = 1'b0;
        chg  = fr && (ch != m_chan);            // R5: reload before count
        base = chg ? ld(m_thr) : m_cnt;
        ex   = fr && (base == 1);
        if (ex)      m_cnt = ld(m_thr);         // R3, R4
        else if (fr) m_cnt = base - 1;
        if (fr) m_chan = ch;
        t = ex && m_mode[2];
        b = chg && m_mode[1];
        s = sv && m_mode[0];
        e.v = t || b || s;
        e.c = t ? 2'b01 : b ? 2'b10 : s ? 2'b11 : 2'b00;
        if (int'(t) + int'(b) + int'(s) > 1) e.req = "R8";
        else if (t)   e.req = "R3";
        else if (b)   e.req = "R6";
        else if (s)   e.req = "R7";
        else if (chg) e.req = "R5";
        else          e.req = "R9";
        q.push_back(e);
    endtask

    // One configuration cycle with no receive activity.
    task automatic wcfg(bit wm, bit [2:0] md, bit wt, bit [7:0] th, bit run);
        exp_t e;
        @(negedge clk);
        frame_i = 1'b0; svc_end_i = 1'b0; run_i = run;
        cfg_mode_wr_i = wm; cfg_mode_i = md;
        cfg_thr_wr_i = wt; cfg_thr_i = th;
        if (wm && !run) m_mode = md;            // R2
        if (wt) m_thr = th;                     // R11: count untouched
        e.v = 1'b0; e.c = 2'b00; e.req = "R2";
        q.push_back(e);
    endtask

    initial begin
        #(WATCHDOG * CLK_PERIOD);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got hang, expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state at the ports
        n_chk++;
        if (bkpt_o !== 1'b0 || bkpt_cause_o !== 2'b00) begin
            n_bad++;
            $display("FAIL R1: got pulse=%0b cause=%0b, expected 0 00", bkpt_o, bkpt_cause_o);
        end
        // R1, R9: all sources off after reset
        for (int i = 0; i < 4; i++) cyc(1'b1, 3'd0, 1'b1);
        cyc(1'b1, 3'd2, 1'b0);
        // R3: budget of 3 with threshold breakpoints enabled
        wcfg(1'b1, 3'b100, 1'b1, 8'd3, 1'b0);
        cyc(1'b1, 3'd1, 1'b0);
        for (int i = 0; i < 7; i++) cyc(1'b1, 3'd1, 1'b0);
        // R2: mode write while running is ignored
        wcfg(1'b1, 3'b000, 1'b0, 8'd0, 1'b1);
        for (int i = 0; i < 4; i++) cyc(1'b1, 3'd1, i[0]);
        // R11: new budget waits for the next reload
        wcfg(1'b0, 3'b000, 1'b1, 8'd5, 1'b1);
        for (int i = 0; i < 12; i++) cyc(1'b1, 3'd1, 1'b0);
        // R6, R7, R8: all sources with coincidences
        wcfg(1'b1, 3'b111, 1'b1, 8'd2, 1'b0);
        for (int i = 0; i < 60; i++)
            cyc((i % 3) != 2, 3'((i / 5) % 4), (i % 4) == 0);
        // R4: budget of 1 expires on every frame
        wcfg(1'b0, 3'b000, 1'b1, 8'd1, 1'b0);
        for (int i = 0; i < 5; i++) cyc(1'b1, 3'd6, 1'b1);
        // R4: zero budget means 256 frames
        wcfg(1'b1, 3'b100, 1'b1, 8'd0, 1'b0);
        cyc(1'b1, 3'd5, 1'b0);
        for (int i = 0; i < 259; i++) cyc(1'b1, 3'd5, 1'b0);
        // R9: service only; counting goes on unseen
        wcfg(1'b1, 3'b001, 1'b1, 8'd2, 1'b0);
        for (int i = 0; i < 10; i++) cyc(1'b1, 3'(i % 2), (i % 3) == 0);
        // R10: idle cycles drain the scoreboard
        for (int i = 0; i < 4; i++) cyc(1'b0, 3'd0, 1'b0);
        repeat (3) @(posedge clk);
        #3;
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule